// File: doc/BRIEF.md
# Character and Block-Graphic Cell Renderer

This block produces the colour of every dot of a 32-column by 16-row text screen. The 512 bytes of display memory are read one byte per cell. Each cell is 8 dots wide and 12 lines tall, and sits inside a black border. The top bit of each byte picks the cell's mode, so text cells and block-graphic cells can be mixed freely on the same screen.

A text cell shows a 5-by-7 glyph. The glyph rows come from an external font lookup, which answers in the same cycle. The glyph is drawn in green or orange on black, chosen by a colour-set input, and one byte bit swaps the glyph and background colours. A block-graphic cell is divided into four 4-by-6 quadrants. Each quadrant is either lit in one of eight colours carried in the byte, or left black.

The block runs its own raster counters and marks the first dot of every frame with a pulse. It reads from a memory that has one cycle of read latency. The read for a cell is issued on the last dot of the cell before it.

Top module: `cellvid_renderer`

## Requirements
- R1: While rst_n is low, pix_color is 0 and sof is 0. After rst_n is released, sof goes high within four clocks.
- R2: A frame is H_TOTAL dots by V_TOTAL lines, with defaults of 288 and 208. sof is high for exactly one dot per frame, and that dot is raster position x=0, y=0. Each later dot on pix_color is the next raster position, in row-major order.
- R3: Dots outside the active window are colour 0 (black). The active window covers x from H_LEFT to H_LEFT+255 and y from V_TOP to V_TOP+191, with defaults H_LEFT=16 and V_TOP=8.
- R4: On an active line, mem_rd is high for exactly one dot before each cell's first dot, with mem_addr = row*32 + column. That dot is x=H_LEFT-1 for column 0, or the eighth dot of the previous cell for the other columns. The memory returns the byte on mem_data one clock after mem_rd. mem_rd is low on every other dot.
- R5: A byte with bit 7 clear is a text cell, with font_code = byte[5:0]. On cell lines 3 to 9, font_row = line-3, and dots 2 to 6 of the cell show font_bits[4] down to font_bits[0], where a 1 is a glyph dot. Every other dot of the cell is background.
- R6: Colour index encoding: 0 black, 1 green, 2 yellow, 3 blue, 4 red, 5 buff, 6 cyan, 7 magenta, 8 orange. In a text cell, glyph dots are green (1) when css is 0 and orange (8) when css is 1, and background dots are black.
- R7: In a text cell with byte bit 6 set, glyph dots are black and background dots take the foreground colour from R6.
- R8: A byte with bit 7 set is a block-graphic cell. Bit 3 lights the upper-left quadrant, bit 2 the upper-right, bit 1 the lower-left and bit 0 the lower-right. Upper means cell lines 0 to 5 and left means dots 0 to 3.
- R9: A lit quadrant has colour index 1 + byte[6:4], and an unlit quadrant is black. css has no effect on block-graphic cells.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| css | input | 1 | Text colour set: 0 green, 1 orange |
| mem_rd | output | 1 | Display memory read strobe |
| mem_addr | output | 9 | Display memory byte address |
| mem_data | input | 8 | Byte returned one clock after mem_rd |
| font_code | output | 6 | Character code sent to the font lookup |
| font_row | output | 3 | Glyph row 0 to 6 sent to the font lookup |
| font_bits | input | 5 | Glyph row dots, bit 4 leftmost |
| pix_color | output | 4 | Colour index of the current dot |
| sof | output | 1 | High on the first dot of a frame |

## Verification
On the last dot of a cell, the renderer is still drawing that cell from the held byte while it issues the read for the next cell. On the following dot, it draws from the memory data directly while latching that byte. Adjacent cells are therefore loaded with contrasting contents, such as an unlit block-graphic cell next to a fully lit one, an inverted text cell next to a plain one, and random bytes. Every dot of two whole frames is compared against a model computed from the requirements. A late latch or a stale byte would show up as a wrong colour on a cell's first or last dot. The read strobe and address are also compared on every dot where either the model or the design expects a read.

// File: rtl/cellvid_pkg.sv
package cellvid_pkg;
  localparam int CELL_W   = 8;
  localparam int CELL_H   = 12;
  localparam int GLYPH_X0 = 2;
  localparam int GLYPH_X1 = 6;
  localparam int GLYPH_Y0 = 3;
  localparam int GLYPH_Y1 = 9;
  localparam int QUAD_W   = 4;
  localparam int QUAD_H   = 6;

  typedef enum logic [3:0] {
    COL_BLACK   = 4'd0,
    COL_GREEN   = 4'd1,
    COL_YELLOW  = 4'd2,
    COL_BLUE    = 4'd3,
    COL_RED     = 4'd4,
    COL_BUFF    = 4'd5,
    COL_CYAN    = 4'd6,
    COL_MAGENTA = 4'd7,
    COL_ORANGE  = 4'd8
  } colour_e;

  function automatic colour_e palette(input logic [2:0] code);
    return colour_e'({1'b0, code} + 4'd1);
  endfunction
endpackage

// File: rtl/cellvid_raster.sv
module cellvid_raster
  import cellvid_pkg::*;
#(
  parameter int H_TOTAL = 288,
  parameter int H_LEFT  = 16,
  parameter int V_TOTAL = 208,
  parameter int V_TOP   = 8,
  parameter int COLS    = 32,
  parameter int ROWS    = 16,
  localparam int CW     = $clog2(COLS),
  localparam int RW     = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          frame_first,
  output logic          active,
  output logic [2:0]    dot,
  output logic [3:0]    line,
  output logic [RW-1:0] row,
  output logic          pre_cell,
  output logic [CW-1:0] pre_col
);
  localparam int XW = $clog2(H_TOTAL);
  localparam int YW = $clog2(V_TOTAL);
  localparam logic [XW-1:0] H_LEFT_C = XW'(H_LEFT);
  localparam logic [XW-1:0] H_PRE_C  = XW'(H_LEFT - 1);
  localparam logic [XW-1:0] H_END_C  = XW'(H_LEFT + COLS * CELL_W);
  localparam logic [XW-1:0] H_LAST_C = XW'(H_TOTAL - 1);
  localparam logic [YW-1:0] V_TOP_C  = YW'(V_TOP);
  localparam logic [YW-1:0] V_END_C  = YW'(V_TOP + ROWS * CELL_H);
  localparam logic [YW-1:0] V_LAST_C = YW'(V_TOTAL - 1);

  logic [XW-1:0] x_q, x_d, ax;
  logic [YW-1:0] y_q, y_d;
  logic [3:0]    line_q, line_d;
  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col;
  logic          h_act, v_act, line_end;

  always_comb begin
    ax       = x_q - H_LEFT_C;
    col      = CW'(ax >> 3);
    h_act    = (x_q >= H_LEFT_C) && (x_q < H_END_C);
    v_act    = (y_q >= V_TOP_C) && (y_q < V_END_C);
    line_end = (x_q == H_LAST_C);
    x_d      = line_end ? '0 : x_q + XW'(1);
    y_d      = (y_q == V_LAST_C) ? '0 : y_q + YW'(1);
    line_d   = line_q;
    row_d    = row_q;
    if (y_d == V_TOP_C) begin
      line_d = '0;
      row_d  = '0;
    end else if (v_act) begin
      if (line_q == 4'(CELL_H - 1)) begin
        line_d = '0;
        row_d  = row_q + RW'(1);
      end else begin
        line_d = line_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      line_q <= '0;
      row_q  <= '0;
    end else begin
      x_q <= x_d;
      if (line_end) begin
        y_q    <= y_d;
        line_q <= line_d;
        row_q  <= row_d;
      end
    end
  end

  assign frame_first = (x_q == '0) && (y_q == '0);
  assign active      = h_act && v_act;
  assign dot         = ax[2:0];
  assign line        = line_q;
  assign row         = row_q;
  assign pre_cell    = v_act && ((x_q == H_PRE_C) ||
                       (h_act && (ax[2:0] == 3'd7) && (col != CW'(COLS - 1))));
  assign pre_col     = (x_q == H_PRE_C) ? '0 : col + CW'(1);
endmodule

// File: rtl/cellvid_fetch.sv
module cellvid_fetch #(
  parameter int COLS = 32,
  parameter int ROWS = 16,
  localparam int CW  = $clog2(COLS),
  localparam int RW  = $clog2(ROWS),
  localparam int AW  = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_cell,
  input  logic [CW-1:0] pre_col,
  input  logic [RW-1:0] row,
  input  logic          cell_first,
  input  logic [7:0]    mem_data,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    cur_byte
);
  logic [7:0] hold_q;

  assign mem_rd   = pre_cell;
  assign mem_addr = AW'(row) * AW'(COLS) + AW'(pre_col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (cell_first) hold_q <= mem_data;
  end

  assign cur_byte = cell_first ? mem_data : hold_q;

  // R4
  fetch_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R4
  fetch_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> cell_first);
endmodule

// File: rtl/cellvid_shader.sv
module cellvid_shader
  import cellvid_pkg::*;
(
  input  logic       active,
  input  logic [2:0] dot,
  input  logic [3:0] line,
  input  logic [7:0] cell_byte,
  input  logic       css,
  input  logic [4:0] font_bits,
  output logic [5:0] font_code,
  output logic [2:0] font_row,
  output colour_e    colour
);
  logic       in_gx, in_gy, glyph_on, upper, left, quad_on;
  logic [2:0] gidx;
  logic [4:0] shifted;
  colour_e    fg;

  always_comb begin
    in_gx     = (dot >= 3'(GLYPH_X0)) && (dot <= 3'(GLYPH_X1));
    in_gy     = (line >= 4'(GLYPH_Y0)) && (line <= 4'(GLYPH_Y1));
    font_code = cell_byte[5:0];
    font_row  = in_gy ? 3'(line - 4'(GLYPH_Y0)) : 3'd0;
    gidx      = 3'(GLYPH_X1) - dot;
    shifted   = font_bits >> gidx;
    glyph_on  = in_gx && in_gy && shifted[0];
    fg        = css ? COL_ORANGE : COL_GREEN;
    upper     = line < 4'(QUAD_H);
    left      = dot < 3'(QUAD_W);
    quad_on   = cell_byte[{upper, left}];
    if (!active)
      colour = COL_BLACK;
    else if (cell_byte[7])
      colour = quad_on ? palette(cell_byte[6:4]) : COL_BLACK;
    else
      colour = (glyph_on ^ cell_byte[6]) ? fg : COL_BLACK;
  end
endmodule

// File: rtl/cellvid_renderer.sv
module cellvid_renderer
  import cellvid_pkg::*;
#(
  parameter int H_TOTAL = 288,
  parameter int H_LEFT  = 16,
  parameter int V_TOTAL = 208,
  parameter int V_TOP   = 8,
  parameter int COLS    = 32,
  parameter int ROWS    = 16,
  localparam int CW     = $clog2(COLS),
  localparam int RW     = $clog2(ROWS),
  localparam int AW     = $clog2(COLS * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          css,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_data,
  output logic [5:0]    font_code,
  output logic [2:0]    font_row,
  input  logic [4:0]    font_bits,
  output logic [3:0]    pix_color,
  output logic          sof
);
  logic [1:0]    sync_q;
  logic          rst_s;
  logic          frame_first, active, pre_cell, cell_first;
  logic [2:0]    dot;
  logic [3:0]    line;
  logic [RW-1:0] row;
  logic [CW-1:0] pre_col;
  logic [7:0]    cur_byte;
  colour_e       colour;
  logic [3:0]    pix_q, pix_d;
  logic          sof_q, sof_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_s = sync_q[1];

  cellvid_raster #(
    .H_TOTAL(H_TOTAL), .H_LEFT(H_LEFT), .V_TOTAL(V_TOTAL), .V_TOP(V_TOP),
    .COLS(COLS), .ROWS(ROWS)
  ) raster_i (
    .clk(clk), .rst_n(rst_s), .frame_first(frame_first), .active(active),
    .dot(dot), .line(line), .row(row), .pre_cell(pre_cell), .pre_col(pre_col)
  );

  assign cell_first = active && (dot == 3'd0);

  cellvid_fetch #(.COLS(COLS), .ROWS(ROWS)) fetch_i (
    .clk(clk), .rst_n(rst_s), .pre_cell(pre_cell), .pre_col(pre_col),
    .row(row), .cell_first(cell_first), .mem_data(mem_data),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .cur_byte(cur_byte)
  );

  cellvid_shader shader_i (
    .active(active), .dot(dot), .line(line), .cell_byte(cur_byte),
    .css(css), .font_bits(font_bits), .font_code(font_code),
    .font_row(font_row), .colour(colour)
  );

  always_comb begin
    pix_d = colour;
    sof_d = frame_first;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pix_q <= '0;
      sof_q <= 1'b0;
    end else begin
      pix_q <= pix_d;
      sof_q <= sof_d;
    end
  end

  assign pix_color = pix_q;
  assign sof       = sof_q;

  // R3
  border_black_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !active |=> (pix_color == 4'd0));
  // R9
  semi_palette_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (active && cur_byte[7]) |=>
      ((pix_color == 4'd0) || (pix_color == {1'b0, $past(cur_byte[6:4])} + 4'd1)));
  // R6
  text_green_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (active && !cur_byte[7] && !css) |=> ((pix_color == 4'd0) || (pix_color == 4'd1)));
  // R2
  sof_single_chk: assert property (@(posedge clk) disable iff (!rst_s)
    sof |=> !sof);
endmodule

// File: tb/cellvid_renderer_tb.sv
module cellvid_renderer_tb_top;
  localparam int HT = 288, HL = 16, VT = 208, VTOP = 8;
  localparam int FRAME = HT * VT;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       css;
  logic       mem_rd;
  logic [8:0] mem_addr;
  logic [7:0] mem_data;
  logic [5:0] font_code;
  logic [2:0] font_row;
  logic [4:0] font_bits;
  logic [3:0] pix_color;
  logic       sof;
  logic [7:0] ram [512];
  int         n_cmp = 0, n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  function automatic logic [4:0] font_fn(input logic [5:0] c, input logic [2:0] r);
    return 5'(int'(c) * 7 + int'(r) * 13) ^ {c[1:0], r};
  endfunction

  assign font_bits = font_fn(font_code, font_row);

  always @(posedge clk) if (mem_rd) mem_data <= ram[mem_addr];

  cellvid_renderer dut_i (
    .clk(clk), .rst_n(rst_n), .css(css), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_data(mem_data), .font_code(font_code), .font_row(font_row),
    .font_bits(font_bits), .pix_color(pix_color), .sof(sof)
  );

  function automatic logic [3:0] exp_pix(input int x, input int y, input bit cs);
    int ax, ay, dt, ln, idx;
    logic [7:0] b;
    logic [4:0] fb;
    bit lit;
    if (x < HL || x >= HL + 256 || y < VTOP || y >= VTOP + 192) return 4'd0;
    ax = x - HL; ay = y - VTOP; dt = ax % 8; ln = ay % 12;
    b = ram[(ay / 12) * 32 + ax / 8];
    if (b[7]) begin
      idx = (ln < 6 ? 2 : 0) + (dt < 4 ? 1 : 0);
      return b[idx] ? {1'b0, b[6:4]} + 4'd1 : 4'd0;
    end
    lit = 0;
    if (ln >= 3 && ln <= 9 && dt >= 2 && dt <= 6) begin
      fb = font_fn(b[5:0], 3'(ln - 3));
      lit = fb[6 - dt];
    end
    return (lit ^ b[6]) ? (cs ? 4'd8 : 4'd1) : 4'd0;
  endfunction

  function automatic string tag_of(input int x, input int y);
    int ax, ay;
    logic [7:0] b;
    if (x < HL || x >= HL + 256 || y < VTOP || y >= VTOP + 192) return "R3";
    ax = x - HL; ay = y - VTOP;
    b = ram[(ay / 12) * 32 + ax / 8];
    if (b[7]) return "R8/R9";
    if (b[6]) return "R7";
    return "R5/R6";
  endfunction

  task automatic fill_ram(input bit second);
    for (int i = 0; i < 512; i++) ram[i] = 8'($urandom);
    ram[0] = 8'h00; ram[1] = 8'h40; ram[2] = 8'h80; ram[3] = 8'hFF;
    ram[4] = 8'h8A; ram[5] = 8'hF5; ram[31] = 8'h3F; ram[32] = 8'hC0;
    ram[33] = 8'h7F; ram[511] = second ? 8'hE9 : 8'h40;
  endtask

  task automatic check_dot(input int k);
    int x, y, q, qx, qy;
    logic [3:0] e;
    bit erd;
    logic [8:0] ea;
    x = k % HT; y = k / HT;
    e = exp_pix(x, y, css);
    n_cmp++;
    if (pix_color !== e) begin
      n_bad++;
      $display("FAIL %s x=%0d y=%0d: pix_color got %0d expected %0d", tag_of(x, y), x, y, pix_color, e);
    end
    n_cmp++;
    if (sof !== (k == 0)) begin
      n_bad++;
      $display("FAIL R2 x=%0d y=%0d: sof got %0b expected %0b", x, y, sof, (k == 0));
    end
    q = (k + 1) % FRAME; qx = q % HT; qy = q / HT;
    erd = (qy >= VTOP && qy < VTOP + 192) &&
          (qx == HL - 1 || (qx >= HL && qx < HL + 256 && (qx - HL) % 8 == 7 && (qx - HL) / 8 != 31));
    ea = 9'(((qy - VTOP) / 12) * 32 + ((qx == HL - 1) ? 0 : (qx - HL) / 8 + 1));
    if (erd || mem_rd) begin
      n_cmp++;
      if (mem_rd !== erd || (erd && mem_addr !== ea)) begin
        n_bad++;
        $display("FAIL R4 x=%0d y=%0d: rd/addr got %0b/%0d expected %0b/%0d", qx, qy, mem_rd, mem_addr, erd, ea);
      end
    end
  endtask

  task automatic run_frame(input bit first, input bit swap_at_end);
    for (int k = 0; k < FRAME; k++) begin
      if (!(first && k == 0)) @(negedge clk);
      check_dot(k);
      if (swap_at_end && k == FRAME - 100) begin
        fill_ram(1'b1);
        css = 1'b1;
      end
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    int waited;
    void'($urandom(32'h00C0FFEE));
    rst_n = 1'b0; css = 1'b0;
    fill_ram(1'b0);
    repeat (4) begin
      @(negedge clk);
      n_cmp++;
      if (pix_color !== 4'd0 || sof !== 1'b0) begin
        n_bad++;
        $display("FAIL R1 in reset: pix/sof got %0d/%0b expected 0/0", pix_color, sof);
      end
    end
    rst_n = 1'b1;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (sof !== 1'b1 && waited < 8);
    n_cmp++;
    if (sof !== 1'b1 || waited > 4) begin
      n_bad++;
      $display("FAIL R1 after release: sof after %0d clocks got %0b expected 1 within 4", waited, sof);
    end
    run_frame(1'b1, 1'b1);
    run_frame(1'b0, 1'b0);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      summary();
    end
  end
endmodule